// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches a running calendar clock and raises an interrupt when the time reaches a programmed alarm. Software programs four alarm bytes through a byte write port: seconds, minutes, hours and day of month, all in BCD. Bit 7 of each byte is a repeat mask. A set mask drops that field from the comparison. The four mask bits together pick one of five repeat rates: monthly, daily, hourly, once a minute or every second.

The clock counter sits outside this block. Once per second it presents a one-cycle `tick` together with the current BCD seconds, minutes, hours and date. On each tick the unit compares the unmasked alarm fields against that time. On a hit, a two-state machine (`ST_IDLE`, `ST_FIRE`) drives `irq` high for exactly one clock cycle.

The machine has three transitions:
- `ARM_TO_FIRE` goes from `ST_IDLE` to `ST_FIRE` on a matching tick.
- `FIRE_AGAIN` stays in `ST_FIRE` on a matching tick.
- `FIRE_DONE` returns from `ST_FIRE` to `ST_IDLE` on any other cycle.

Writes that carry an out-of-range BCD value are refused, and the register keeps its previous content.

Top module: `rtc_alarm_match`

## Requirements
- R1: The alarm bytes sit at window offsets 0x2 (seconds), 0x3 (minutes), 0x4 (hours) and 0x5 (date). A read returns the full stored byte, including bit 7. Any other offset reads 0x00, and writes to it change nothing.
- R2: A write to the seconds or minutes byte is stored only when bits 6:4 are at most 5 and bits 3:0 are at most 9 (BCD 00..59). Otherwise the old byte stays.
- R3: A write to the hours byte is stored only when bits 5:0 form BCD 00..23. Otherwise the old byte stays.
- R4: A write to the date byte is stored only when bits 3:0 are at most 9. Otherwise the old byte stays.
- R5: A synchronous reset clears all four alarm bytes to 0x00 and holds `irq` low.
- R6: With all four mask bits clear (monthly), a tick fires only when all four of the following match the inputs:
  - date bits 5:0
  - hour bits 5:0
  - minute bits 6:0
  - second bits 6:0
- R7: With only the date mask set (daily), the date is ignored, and hour, minute and second must match.
- R8: With the date and hour masks set and the others clear (hourly), minute and second must match.
- R9: With the date, hour and minute masks set and the seconds mask clear (once a minute), only the seconds must match.
- R10: Every other mask combination fires on every tick.
- R11: `irq` is high for exactly the one cycle after a matching tick, and it is never high in the cycle after a cycle without a tick.
- R12: A write landing in the same cycle as a tick does not affect that tick. The comparison uses the alarm bytes as they were before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset in the register window |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 4 | Read offset in the register window |
| rd_data | output | 8 | Read byte (combinational from rd_addr) |
| tick | input | 1 | One-cycle pulse once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A register write and a compare tick can fall in the same clock cycle. The bench provokes this by issuing the tick and a write to the seconds byte in one cycle. The current time matches the old alarm value, and the written value no longer matches it. The scoreboard expects a pulse in the next cycle, computed from the shadow copy before that write is applied. It then expects no pulse on the following tick, computed from the shadow copy after the write.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MIN,
        RATE_SEC
    } rate_e;

    typedef enum logic {
        ST_IDLE,
        ST_FIRE
    } fsm_e;

    typedef struct packed {
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } alarm_t;

    // BCD 00..59 on a 7-bit field
    function automatic logic bcd_upto59(input logic [6:0] v);
        return (v[6:4] <= 3'd5) && (v[3:0] <= 4'd9);
    endfunction

    // BCD 00..23 on a 6-bit field
    function automatic logic bcd_upto23(input logic [5:0] v);
        return (v[3:0] <= 4'd9) &&
               ((v[5:4] < 2'd2) || ((v[5:4] == 2'd2) && (v[3:0] <= 4'd3)));
    endfunction

    function automatic logic bcd_digit(input logic [3:0] v);
        return v <= 4'd9;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int OFF_SEC  = 2,
    parameter int OFF_MIN  = 3,
    parameter int OFF_HOUR = 4,
    parameter int OFF_DATE = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [6:0]        sec_val,
    output logic [6:0]        min_val,
    output logic [5:0]        hour_val,
    output logic [5:0]        date_val,
    output logic [3:0]        mask
);

    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFF_SEC);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(OFF_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(OFF_HOUR);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFF_DATE);

    alarm_t al_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            al_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:   if (bcd_upto59(wr_data[6:0])) al_q.sec  <= wr_data;
                A_MIN:   if (bcd_upto59(wr_data[6:0])) al_q.min  <= wr_data;
                A_HOUR:  if (bcd_upto23(wr_data[5:0])) al_q.hour <= wr_data;
                A_DATE:  if (bcd_digit(wr_data[3:0]))  al_q.date <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = al_q.sec;
            A_MIN:   rd_data = al_q.min;
            A_HOUR:  rd_data = al_q.hour;
            A_DATE:  rd_data = al_q.date;
            default: rd_data = 8'h00;
        endcase
    end

    assign sec_val  = al_q.sec[6:0];
    assign min_val  = al_q.min[6:0];
    assign hour_val = al_q.hour[5:0];
    assign date_val = al_q.date[5:0];
    assign mask     = {al_q.date[7], al_q.hour[7], al_q.min[7], al_q.sec[7]};

    assert_reject_sec_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_SEC && !bcd_upto59(wr_data[6:0])) |=> $stable(al_q.sec));

    assert_reject_min_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_MIN && !bcd_upto59(wr_data[6:0])) |=> $stable(al_q.min));

    assert_reject_hour_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_HOUR && !bcd_upto23(wr_data[5:0])) |=> $stable(al_q.hour));

    assert_reject_date_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DATE && !bcd_digit(wr_data[3:0])) |=> $stable(al_q.date));

    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> (al_q == '0));

endmodule

// File: rtl/rtc_alarm_rate.sv
`timescale 1ns/1ps
module rtc_alarm_rate
    import rtc_alarm_pkg::*;
(
    input  logic [3:0] mask,   // {date, hour, min, sec}
    output rate_e      rate
);

    always_comb begin
        case (mask)
            4'b0000: rate = RATE_MONTH;
            4'b1000: rate = RATE_DAY;
            4'b1100: rate = RATE_HOUR;
            4'b1110: rate = RATE_MIN;
            default: rate = RATE_SEC;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int FIELDS = 4
) (
    input  rate_e      rate,
    input  logic [6:0] al_sec,
    input  logic [6:0] al_min,
    input  logic [5:0] al_hour,
    input  logic [5:0] al_date,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [5:0] now_hour,
    input  logic [5:0] now_date,
    output logic       hit
);

    logic [FIELDS-1:0] eq;
    logic [FIELDS-1:0] need;

    assign eq = {al_date == now_date, al_hour == now_hour,
                 al_min == now_min, al_sec == now_sec};

    // fields that must agree, index 0 = seconds upward
    always_comb begin
        unique case (rate)
            RATE_MONTH: need = 4'b1111;
            RATE_DAY:   need = 4'b0111;
            RATE_HOUR:  need = 4'b0011;
            RATE_MIN:   need = 4'b0001;
            default:    need = 4'b0000;
        endcase
    end

    logic [FIELDS-1:0] ok;
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign ok[g] = eq[g] | ~need[g];
    end

    assign hit = &ok;

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [5:0] now_hour,
    input  logic [5:0] now_date,
    output logic       irq
);

    logic [6:0] al_sec, al_min;
    logic [5:0] al_hour, al_date;
    logic [3:0] mask;
    rate_e      rate;
    logic       hit;
    fsm_e       state_q, state_d;

    rtc_alarm_regs #(.ADDR_W(4)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_val(al_sec), .min_val(al_min), .hour_val(al_hour),
        .date_val(al_date), .mask(mask)
    );

    rtc_alarm_rate u_rate (.mask(mask), .rate(rate));

    rtc_alarm_cmp u_cmp (
        .rate(rate), .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
        .al_date(al_date), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .hit(hit)
    );

    // next-state: ARM_TO_FIRE, FIRE_AGAIN, FIRE_DONE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = (tick && hit) ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = (tick && hit) ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == ST_FIRE);
    end

    assert_needs_tick_R11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !irq);

    assert_every_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && rate == RATE_SEC) |=> irq);

    assert_month_date_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && rate == RATE_MONTH && al_date != now_date) |=> !irq);

    assert_reset_quiet_R5: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_date = 6'h01;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] sh [0:15];
    bit    exp_q [$];
    string req_q [$];

    always #2.5 clk = ~clk;

    rtc_alarm_match uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // shadow update from the requirements
    function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'h2, 4'h3: if (d[6:4] <= 5 && d[3:0] <= 9) sh[a] = d;
            4'h4: if (d[3:0] <= 9 && (d[5:4] < 2 || (d[5:4] == 2 && d[3:0] <= 3))) sh[a] = d;
            4'h5: if (d[3:0] <= 9) sh[a] = d;
            default: ;
        endcase
    endfunction

    function automatic bit model_hit(input logic [6:0] s, input logic [6:0] m,
                                     input logic [5:0] h, input logic [5:0] d);
        bit es, em, eh, ed;
        es = sh[2][6:0] == s;
        em = sh[3][6:0] == m;
        eh = sh[4][5:0] == h;
        ed = sh[5][5:0] == d;
        case ({sh[5][7], sh[4][7], sh[3][7], sh[2][7]})
            4'b0000: return ed && eh && em && es;
            4'b1000: return eh && em && es;
            4'b1100: return em && es;
            4'b1110: return es;
            default: return 1'b1;
        endcase
    endfunction

    // driver: one cycle of stimulus, tick expectation pushed from pre-write shadow
    task automatic cyc(input bit t, input logic [6:0] s, input logic [6:0] m,
                       input logic [5:0] h, input logic [5:0] d,
                       input bit we, input logic [3:0] wa, input logic [7:0] wd,
                       input string req);
        @(negedge clk);
        tick = t; now_sec = s; now_min = m; now_hour = h; now_date = d;
        wr_en = we; wr_addr = wa; wr_data = wd;
        if (t) begin
            exp_q.push_back(model_hit(s, m, h, d));
            req_q.push_back(req);
        end
        if (we) model_write(wa, wd);
    endtask

    task automatic idle();
        cyc(1'b0, now_sec, now_min, now_hour, now_date, 1'b0, 4'h0, 8'h00, "");
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b0, now_sec, now_min, now_hour, now_date, 1'b1, a, d, "");
        idle();
    endtask

    task automatic tk(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                      input logic [5:0] d, input string req);
        cyc(1'b1, s, m, h, d, 1'b0, 4'h0, 8'h00, req);
        idle();
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data == sh[a], req, rd_data, sh[a]);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (!done) begin
            if (exp_q.size() > 0) begin
                bit e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(irq == e, r, irq, e);
            end else begin
                chk(irq == 1'b0, "R11 idle", irq, 0);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) sh[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 reset state, R1 unused offset
        for (int i = 2; i < 6; i++) rd(4'(i), "R5 reset value");
        rd(4'h0, "R1 unused offset");

        // monthly alarm
        wr(4'h2, 8'h30); wr(4'h3, 8'h15); wr(4'h4, 8'h12); wr(4'h5, 8'h07);
        for (int i = 2; i < 6; i++) rd(4'(i), "R1 read back");
        tk(7'h30, 7'h15, 6'h12, 6'h07, "R6 exact match");
        tk(7'h30, 7'h15, 6'h12, 6'h08, "R6 date differs");
        tk(7'h31, 7'h15, 6'h12, 6'h07, "R6 second differs");

        // range checks
        wr(4'h2, 8'h60); rd(4'h2, "R2 sec tens 6 rejected");
        wr(4'h2, 8'h5A); rd(4'h2, "R2 sec units A rejected");
        wr(4'h2, 8'h59); rd(4'h2, "R2 sec 59 accepted");
        wr(4'h3, 8'h7F); rd(4'h3, "R2 min 7F rejected");
        wr(4'h4, 8'h24); rd(4'h4, "R3 hour 24 rejected");
        wr(4'h4, 8'h1A); rd(4'h4, "R3 hour 1A rejected");
        wr(4'h4, 8'h23); rd(4'h4, "R3 hour 23 accepted");
        wr(4'h5, 8'h0A); rd(4'h5, "R4 date 0A rejected");
        wr(4'h5, 8'h31); rd(4'h5, "R4 date 31 accepted");
        wr(4'h9, 8'h55); rd(4'h9, "R1 write to unused offset");

        // daily: date mask, hour 12 min 15 sec 30
        wr(4'h2, 8'h30); wr(4'h4, 8'h12); wr(4'h5, 8'h87);
        rd(4'h5, "R1 mask bit stored");
        tk(7'h30, 7'h15, 6'h12, 6'h21, "R7 date ignored");
        tk(7'h30, 7'h16, 6'h12, 6'h21, "R7 minute differs");

        // hourly
        wr(4'h4, 8'h92);
        tk(7'h30, 7'h15, 6'h03, 6'h02, "R8 hour ignored");
        tk(7'h29, 7'h15, 6'h03, 6'h02, "R8 second differs");

        // once a minute
        wr(4'h3, 8'h95);
        tk(7'h30, 7'h44, 6'h05, 6'h02, "R9 minute ignored");
        tk(7'h31, 7'h44, 6'h05, 6'h02, "R9 second differs");

        // every second: all masks, then sec mask only
        wr(4'h2, 8'hB0);
        tk(7'h01, 7'h02, 6'h03, 6'h04, "R10 all masks");
        wr(4'h3, 8'h15); wr(4'h4, 8'h12); wr(4'h5, 8'h07);
        rd(4'h2, "R1 sec with mask");
        tk(7'h00, 7'h00, 6'h00, 6'h01, "R10 sec mask only");

        // R11 back-to-back matching ticks, then a gap
        cyc(1'b1, 7'h00, 7'h00, 6'h00, 6'h01, 1'b0, 4'h0, 8'h00, "R11 tick one");
        cyc(1'b1, 7'h01, 7'h00, 6'h00, 6'h01, 1'b0, 4'h0, 8'h00, "R11 tick two");
        idle(); idle();

        // R12 write coinciding with tick: monthly 07 12:15:30
        wr(4'h2, 8'h30);
        cyc(1'b1, 7'h30, 7'h15, 6'h12, 6'h07, 1'b1, 4'h2, 8'h45, "R12 old value used");
        idle();
        tk(7'h30, 7'h15, 6'h12, 6'h07, "R12 new value after");
        rd(4'h2, "R12 write landed");

        // R5 reset clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) sh[i] = 8'h00;
        for (int i = 2; i < 6; i++) rd(4'(i), "R5 cleared after reset");

        repeat (3) idle();
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule